// File: doc/BRIEF.md
# Ancillary Packet Admission Filter

The filter watches a stream of 10-bit ancillary data words and picks out packets that start with the three-word preamble 000h, 3FFh, 3FFh. The two words after the preamble are the packet's primary identifier (DID) and its secondary identifier or block number (SDID). Once both have arrived, the filter compares them with two programmable identifiers under two per-bit masks. If parity checking is on, it also checks the parity of both words. A packet that passes is forwarded whole to the write side of a downstream FIFO: preamble, identifiers, count word, user words and checksum. A packet that fails is consumed and discarded. Words outside any packet are never forwarded.

The input side (`s_*`) and the FIFO write side (`m_*`) are valid/ready ports. A word moves when valid and ready are both high at a rising clock edge. `m_valid` never depends on `m_ready`. While the preamble and identifiers are being collected, the filter keeps `s_ready` high and forwards nothing. After an admit decision, it replays the five buffered words with `s_ready` low. During that replay `m_data` is held while `m_ready` is low. In the body of an admitted packet, `s_ready` follows `m_ready` and `m_valid` follows `s_valid`. In the body of a rejected packet, `s_ready` stays high.

The identifier, mask and parity-control values sit in a small configuration store. All five fields load together on `cfg_we`. For every packet, admitted or not, the filter computes the checksum and raises a one-cycle error pulse on a mismatch.

Top module: `anc_admit_filter`

## Requirements
- R1: A packet begins only after the words 000h, 3FFh, 3FFh are accepted in a row. If 000h arrives mid-preamble, matching restarts. Words outside a packet are accepted with `s_ready` high and never written.
- R2: DID bits [7:0] are compared with the DID identifier only where the DID mask bit is 0. A mask of 00h demands an exact match, and FFh accepts any DID.
- R3: SDID bits [7:0] are compared with the SDID identifier under the SDID mask, with the same rule as R2.
- R4: Out of reset, both masks are FFh, both identifiers are 00h and parity checking is on. All five fields load together at a clock edge with `cfg_we` high and otherwise hold.
- R5: A DID or SDID word has good parity when bit 8 equals the XOR of bits [7:0] and bit 9 is the inverse of bit 8. With `cfg_par_ignore` low, bad parity on either word rejects the packet. With it high, parity plays no part.
- R6: An admitted packet is written in order and unaltered: 000h, 3FFh, 3FFh, DID, SDID, the count word, N user words (N = count word bits [7:0]), and the checksum word.
- R7: A rejected packet produces no write. Its words are accepted with `s_ready` high whatever `m_ready` is.
- R8: The checksum is the 9-bit sum of bits [8:0] of every word from DID through the last user word. The expected word is that sum with bit 9 set to the inverse of its bit 8. On a mismatch, `cs_err` is high for exactly the one cycle after the checksum word is accepted. This holds for admitted and rejected packets alike.
- R9: During replay, `s_ready` is low and `m_valid` and `m_data` stay fixed while `m_ready` is low. In an admitted body, `s_ready` equals `m_ready`.
- R10: A count of zero puts the checksum word directly after the count word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Loads all configuration fields |
| cfg_did_id | input | 8 | DID identifier to match |
| cfg_sdid_id | input | 8 | SDID/block-number identifier to match |
| cfg_did_mask | input | 8 | DID don't-care bits (1 = ignore) |
| cfg_sdid_mask | input | 8 | SDID don't-care bits (1 = ignore) |
| cfg_par_ignore | input | 1 | 1 disables identifier parity rejection |
| s_data | input | 10 | Incoming ancillary word |
| s_valid | input | 1 | Incoming word valid |
| s_ready | output | 1 | Filter accepts the incoming word |
| m_data | output | 10 | FIFO write data |
| m_valid | output | 1 | FIFO write request |
| m_ready | input | 1 | FIFO can take a word |
| cs_err | output | 1 | One-cycle checksum mismatch pulse |

## Verification
The assertions watch the handshake shape on every cycle. Nothing is forwarded while the preamble is being hunted. The replay output holds under back-pressure with input stalled. A rejected body never writes. Configuration holds without a load. An error pulse only follows an accepted checksum word. A hit under a zero mask implies an exact identifier match. The admit decision itself can only be shown by the bench's scenarios: full sweeps of DID and SDID codes under several masks, parity corruption of each word, correct and corrupted checksums, zero-length packets, and preamble resynchronisation. The bench compares the written word sequence against one built arithmetically.

// File: rtl/anc_filt_pkg.sv
package anc_filt_pkg;
  localparam int ANC_W = 10;
  localparam int ID_W  = 8;
  localparam int SUM_W = ANC_W - 1;

  typedef enum logic [2:0] {
    ST_SEEK, ST_DID, ST_SDID, ST_REPLAY, ST_DC, ST_USER, ST_CSUM
  } anc_state_e;

  typedef struct packed {
    logic [ID_W-1:0] did_id;
    logic [ID_W-1:0] sdid_id;
    logic [ID_W-1:0] did_mask;
    logic [ID_W-1:0] sdid_mask;
    logic            par_ign;
  } anc_cfg_t;

  function automatic logic word_par_ok(input logic [ANC_W-1:0] w);
    return (w[ID_W] == ^w[ID_W-1:0]) && (w[ANC_W-1] != w[ID_W]);
  endfunction
endpackage

// File: rtl/anc_filt_cfg.sv
module anc_filt_cfg
  import anc_filt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     we,
  input  anc_cfg_t cfg_in,
  output anc_cfg_t cfg_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q.did_id    <= '0;
      cfg_q.sdid_id   <= '0;
      cfg_q.did_mask  <= '1;
      cfg_q.sdid_mask <= '1;
      cfg_q.par_ign   <= 1'b0;
    end else if (we) begin
      cfg_q <= cfg_in;
    end
  end

  // R4: configuration only changes on a load
  p_cfg_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(cfg_q));
endmodule

// File: rtl/anc_filt_match.sv
module anc_filt_match
  import anc_filt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ANC_W-1:0] word,
  input  logic [ID_W-1:0]  id,
  input  logic [ID_W-1:0]  mask,
  input  logic             par_ign,
  output logic             hit
);
  logic id_eq;
  logic par_good;

  assign id_eq    = ((word[ID_W-1:0] ^ id) & ~mask) == '0;
  assign par_good = par_ign || word_par_ok(word);
  assign hit      = id_eq && par_good;

  // R2 / R3: a zero mask admits only the exact identifier
  p_exact_when_unmasked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0 && hit) |-> (word[ID_W-1:0] == id));
endmodule

// File: rtl/anc_filt_core.sv
module anc_filt_core
  import anc_filt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ANC_W-1:0] s_data,
  input  logic             s_valid,
  output logic             s_ready,
  output logic [ANC_W-1:0] m_data,
  output logic             m_valid,
  input  logic             m_ready,
  output logic [ANC_W-1:0] did_word,
  input  logic             hit_did,
  input  logic             hit_sdid,
  output logic             cs_err
);
  localparam logic [ANC_W-1:0] PRE_LO = '0;
  localparam logic [ANC_W-1:0] PRE_HI = '1;
  localparam int               RPL_LAST = 4;

  anc_state_e       st_q;
  logic [1:0]       pre_q;
  logic [ANC_W-1:0] did_q, sdid_q;
  logic [SUM_W-1:0] sum_q, sum_nxt;
  logic [CNT_W-1:0] cnt_q;
  logic [2:0]       rix_q;
  logic             admit_q, err_q;
  logic             s_fire, m_fire, body;
  logic [ANC_W-1:0] cs_exp;

  assign did_word = did_q;
  assign cs_err   = err_q;
  assign s_fire   = s_valid && s_ready;
  assign m_fire   = m_valid && m_ready;
  assign sum_nxt  = sum_q + s_data[SUM_W-1:0];
  assign cs_exp   = {~sum_q[SUM_W-1], sum_q};
  assign body     = (st_q == ST_DC) || (st_q == ST_USER) || (st_q == ST_CSUM);

  always_comb begin
    s_ready = 1'b1;
    m_valid = 1'b0;
    m_data  = s_data;
    if (st_q == ST_REPLAY) begin
      s_ready = 1'b0;
      m_valid = 1'b1;
      case (rix_q)
        3'd0:    m_data = PRE_LO;
        3'd1,
        3'd2:    m_data = PRE_HI;
        3'd3:    m_data = did_q;
        default: m_data = sdid_q;
      endcase
    end else if (body) begin
      s_ready = admit_q ? m_ready : 1'b1;
      m_valid = admit_q && s_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_SEEK;
      pre_q   <= '0;
      did_q   <= '0;
      sdid_q  <= '0;
      sum_q   <= '0;
      cnt_q   <= '0;
      rix_q   <= '0;
      admit_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      err_q <= 1'b0;
      case (st_q)
        ST_SEEK: if (s_fire) begin
          if (s_data == PRE_LO) pre_q <= 2'd1;
          else if (s_data == PRE_HI && pre_q == 2'd1) pre_q <= 2'd2;
          else if (s_data == PRE_HI && pre_q == 2'd2) begin
            pre_q <= '0;
            st_q  <= ST_DID;
          end else pre_q <= '0;
        end
        ST_DID: if (s_fire) begin
          did_q <= s_data;
          sum_q <= s_data[SUM_W-1:0];
          st_q  <= ST_SDID;
        end
        ST_SDID: if (s_fire) begin
          sdid_q  <= s_data;
          sum_q   <= sum_nxt;
          rix_q   <= '0;
          admit_q <= hit_did && hit_sdid;
          st_q    <= (hit_did && hit_sdid) ? ST_REPLAY : ST_DC;
        end
        ST_REPLAY: if (m_fire) begin
          if (rix_q == 3'(RPL_LAST)) st_q <= ST_DC;
          else rix_q <= rix_q + 3'd1;
        end
        ST_DC: if (s_fire) begin
          sum_q <= sum_nxt;
          cnt_q <= s_data[CNT_W-1:0];
          st_q  <= (s_data[CNT_W-1:0] == '0) ? ST_CSUM : ST_USER;
        end
        ST_USER: if (s_fire) begin
          sum_q <= sum_nxt;
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == CNT_W'(1)) st_q <= ST_CSUM;
        end
        ST_CSUM: if (s_fire) begin
          err_q <= (s_data != cs_exp);
          st_q  <= ST_SEEK;
        end
        default: st_q <= ST_SEEK;
      endcase
    end
  end

  // R1: nothing is written while the preamble and identifiers are collected
  p_hunt_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SEEK || st_q == ST_DID || st_q == ST_SDID) |-> (!m_valid && s_ready));
  // R9: replay output holds under back-pressure
  p_replay_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_REPLAY && !m_ready) |=> (m_valid && $stable(m_data)));
  // R9: input is stalled during replay
  p_replay_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_REPLAY) |-> !s_ready);
  // R7: a rejected body never writes and never stalls
  p_reject_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (body && !admit_q) |-> (!m_valid && s_ready));
  // R8: an error pulse only follows an accepted checksum word
  p_err_after_csum_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> $past(st_q == ST_CSUM && s_fire));
endmodule

// File: rtl/anc_admit_filter.sv
module anc_admit_filter
  import anc_filt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [ID_W-1:0]  cfg_did_id,
  input  logic [ID_W-1:0]  cfg_sdid_id,
  input  logic [ID_W-1:0]  cfg_did_mask,
  input  logic [ID_W-1:0]  cfg_sdid_mask,
  input  logic             cfg_par_ignore,
  input  logic [ANC_W-1:0] s_data,
  input  logic             s_valid,
  output logic             s_ready,
  output logic [ANC_W-1:0] m_data,
  output logic             m_valid,
  input  logic             m_ready,
  output logic             cs_err
);
  localparam int N_ID = 2;

  anc_cfg_t         cfg_in, cfg_q;
  logic [ANC_W-1:0] did_word;
  logic [ANC_W-1:0] cmp_word [N_ID];
  logic [ID_W-1:0]  cmp_id   [N_ID];
  logic [ID_W-1:0]  cmp_mask [N_ID];
  logic [N_ID-1:0]  hit;

  assign cfg_in = '{did_id: cfg_did_id, sdid_id: cfg_sdid_id,
                    did_mask: cfg_did_mask, sdid_mask: cfg_sdid_mask,
                    par_ign: cfg_par_ignore};

  anc_filt_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .cfg_in(cfg_in), .cfg_q(cfg_q)
  );

  assign cmp_word[0] = did_word;
  assign cmp_id[0]   = cfg_q.did_id;
  assign cmp_mask[0] = cfg_q.did_mask;
  assign cmp_word[1] = s_data;
  assign cmp_id[1]   = cfg_q.sdid_id;
  assign cmp_mask[1] = cfg_q.sdid_mask;

  for (genvar k = 0; k < N_ID; k++) begin : g_match
    anc_filt_match u_match (
      .clk(clk), .rst_n(rst_n), .word(cmp_word[k]), .id(cmp_id[k]),
      .mask(cmp_mask[k]), .par_ign(cfg_q.par_ign), .hit(hit[k])
    );
  end

  anc_filt_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n),
    .s_data(s_data), .s_valid(s_valid), .s_ready(s_ready),
    .m_data(m_data), .m_valid(m_valid), .m_ready(m_ready),
    .did_word(did_word), .hit_did(hit[0]), .hit_sdid(hit[1]),
    .cs_err(cs_err)
  );
endmodule

// File: tb/anc_admit_filter_tb.sv
module anc_admit_filter_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_did_id = '0, cfg_sdid_id = '0, cfg_did_mask = '0, cfg_sdid_mask = '0;
  logic       cfg_par_ignore = 1'b0;
  logic [9:0] s_data = '0;
  logic       s_valid = 1'b0;
  logic       s_ready;
  logic [9:0] m_data;
  logic       m_valid;
  logic       m_ready = 1'b1;
  logic       cs_err;

  anc_admit_filter u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_did_id(cfg_did_id),
    .cfg_sdid_id(cfg_sdid_id), .cfg_did_mask(cfg_did_mask),
    .cfg_sdid_mask(cfg_sdid_mask), .cfg_par_ignore(cfg_par_ignore),
    .s_data(s_data), .s_valid(s_valid), .s_ready(s_ready),
    .m_data(m_data), .m_valid(m_valid), .m_ready(m_ready), .cs_err(cs_err)
  );

  always #10 clk = ~clk;

  int total = 0, bad = 0;
  int got_n = 0, err_n = 0, cycles = 0;
  logic [9:0] got [0:299];
  logic [9:0] pw  [0:299];
  int pn = 0;
  int bp_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [7:0] m_id_d = 8'h00, m_id_s = 8'h00, m_mk_d = 8'hFF, m_mk_s = 8'hFF;
  logic m_pign = 1'b0;

  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (bp_mode == 0) m_ready = 1'b1;
    else if (bp_mode == 1) m_ready = lfsr[0] | lfsr[3];
    else m_ready = 1'b0;
  end

  always @(negedge clk) begin
    cycles++;
    if (m_valid && m_ready && got_n < 300) begin
      got[got_n] = m_data;
      got_n++;
    end
    if (cs_err) err_n++;
  end

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    while (cycles < 190000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run hung act=%0d exp=<190000", cycles);
    summary();
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  function automatic logic [9:0] mkw(input logic [7:0] b);
    logic p;
    p = ^b;
    return {~p, p, b};
  endfunction

  function automatic bit pok(input logic [9:0] w);
    return (w[8] == ^w[7:0]) && (w[9] != w[8]);
  endfunction

  function automatic bit exp_admit(input logic [9:0] d, input logic [9:0] s);
    bit m;
    m = (((d[7:0] ^ m_id_d) & ~m_mk_d) == 0) && (((s[7:0] ^ m_id_s) & ~m_mk_s) == 0);
    return m && (m_pign || (pok(d) && pok(s)));
  endfunction

  task automatic set_cfg(input logic [7:0] idd, input logic [7:0] ids,
                         input logic [7:0] mkd, input logic [7:0] mks, input logic pi);
    @(posedge clk); #1;
    cfg_did_id = idd; cfg_sdid_id = ids; cfg_did_mask = mkd;
    cfg_sdid_mask = mks; cfg_par_ignore = pi; cfg_we = 1'b1;
    @(posedge clk); #1;
    cfg_we = 1'b0;
    m_id_d = idd; m_id_s = ids; m_mk_d = mkd; m_mk_s = mks; m_pign = pi;
  endtask

  task automatic build(input logic [9:0] d, input logic [9:0] s, input int n, input bit csbad);
    logic [8:0] sum;
    pw[0] = 10'h000; pw[1] = 10'h3FF; pw[2] = 10'h3FF;
    pw[3] = d; pw[4] = s; pw[5] = mkw(8'(n));
    sum = d[8:0] + s[8:0] + pw[5][8:0];
    for (int i = 0; i < n; i++) begin
      pw[6+i] = 10'(d * 3 + i * 37 + 5);
      sum = sum + pw[6+i][8:0];
    end
    pw[6+n] = {~sum[8], sum} ^ (csbad ? 10'h001 : 10'h000);
    pn = 7 + n;
  endtask

  task automatic send_word(input logic [9:0] w);
    s_data = w;
    s_valid = 1'b1;
    forever begin
      @(negedge clk);
      if (s_ready) begin
        @(posedge clk); #1;
        break;
      end
      @(posedge clk); #1;
    end
    s_valid = 1'b0;
  endtask

  task automatic verify(input string tag, input bit adm, input bit csbad);
    int mism;
    repeat (3) @(posedge clk);
    #1;
    if (adm) begin
      mism = 0;
      for (int i = 0; i < pn; i++) if (got[i] != pw[i]) mism++;
      chk(got_n == pn && mism == 0, {tag, " admitted packet written whole"}, got_n, pn);
    end else begin
      chk(got_n == 0, {tag, " rejected packet not written"}, got_n, 0);
    end
    chk(err_n == int'(csbad), {tag, " checksum error pulses"}, err_n, int'(csbad));
    got_n = 0;
    err_n = 0;
  endtask

  task automatic run_pkt(input string tag, input logic [9:0] d, input logic [9:0] s,
                         input int n, input bit csbad);
    got_n = 0; err_n = 0;
    build(d, s, n, csbad);
    for (int i = 0; i < pn; i++) send_word(pw[i]);
    verify(tag, exp_admit(d, s), csbad);
  endtask

  int hits;

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!m_valid && s_ready && !cs_err, "R1 reset state idle", {m_valid, s_ready, cs_err}, 3'b010);

    // R4: defaults admit anything with good parity
    run_pkt("R4 default config", mkw(8'h5A), mkw(8'hC3), 3, 1'b0);

    // R2: exact DID sweep, one admitted code
    set_cfg(8'h61, 8'h00, 8'h00, 8'hFF, 1'b0);
    hits = 0;
    for (int v = 0; v < 256; v++) begin
      if (exp_admit(mkw(8'(v)), mkw(8'h22))) hits++;
      run_pkt("R2 exact DID sweep", mkw(8'(v)), mkw(8'h22), v % 4, 1'b0);
    end
    chk(hits == 1, "R2 exact mask admits one code", hits, 1);

    // R2: partial DID mask, R10 zero counts included
    set_cfg(8'hA3, 8'h00, 8'h0F, 8'hFF, 1'b0);
    for (int v = 0; v < 256; v++)
      run_pkt("R2 R10 masked DID sweep", mkw(8'(v)), mkw(8'h10), (v + 1) % 3, 1'b0);

    // R3: SDID sweep under mask C0
    set_cfg(8'h00, 8'h15, 8'hFF, 8'hC0, 1'b0);
    hits = 0;
    for (int v = 0; v < 256; v++) begin
      if (exp_admit(mkw(8'h44), mkw(8'(v)))) hits++;
      run_pkt("R3 masked SDID sweep", mkw(8'h44), mkw(8'(v)), 1, 1'b0);
    end
    chk(hits == 4, "R3 mask C0 admits four codes", hits, 4);

    // R5: parity corruption
    set_cfg(8'h00, 8'h00, 8'hFF, 8'hFF, 1'b0);
    run_pkt("R5 DID bit8 flipped", mkw(8'h33) ^ 10'h100, mkw(8'h01), 2, 1'b0);
    run_pkt("R5 DID bit9 wrong", mkw(8'h33) ^ 10'h200, mkw(8'h01), 2, 1'b0);
    run_pkt("R5 SDID bad parity", mkw(8'h33), mkw(8'h01) ^ 10'h100, 2, 1'b0);
    set_cfg(8'h00, 8'h00, 8'hFF, 8'hFF, 1'b1);
    run_pkt("R5 parity ignored", mkw(8'h33) ^ 10'h100, mkw(8'h01) ^ 10'h300, 2, 1'b0);

    // R8: bad checksum on admitted and rejected packets
    run_pkt("R8 admitted bad checksum", mkw(8'h70), mkw(8'h08), 5, 1'b1);
    set_cfg(8'h11, 8'h00, 8'h00, 8'hFF, 1'b0);
    run_pkt("R8 R7 rejected bad checksum", mkw(8'h70), mkw(8'h08), 4, 1'b1);
    run_pkt("R10 zero count admitted", mkw(8'h11), mkw(8'h99), 0, 1'b0);

    // R7: rejected packet consumed while FIFO refuses
    bp_mode = 2;
    run_pkt("R7 rejected under full stall", mkw(8'h12), mkw(8'h00), 6, 1'b0);
    bp_mode = 0;

    // R9: replay holds under stall
    set_cfg(8'h00, 8'h00, 8'hFF, 8'hFF, 1'b0);
    got_n = 0; err_n = 0;
    build(mkw(8'h2B), mkw(8'h5C), 2, 1'b0);
    bp_mode = 2;
    for (int i = 0; i < 5; i++) send_word(pw[i]);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(m_valid && m_data == 10'h000 && !s_ready, "R9 replay held under stall",
          {m_valid, s_ready, m_data}, {1'b1, 1'b0, 10'h000});
    end
    bp_mode = 1;
    for (int i = 5; i < pn; i++) send_word(pw[i]);
    verify("R9 R6 stalled replay", 1'b1, 1'b0);

    // R9: random back-pressure
    for (int p = 0; p < 20; p++)
      run_pkt("R9 random back-pressure", mkw(8'(p * 11)), mkw(8'(p + 3)), p % 6, p % 5 == 0);
    bp_mode = 0;

    // R1: junk and broken preambles are not written
    got_n = 0;
    send_word(10'h3FF); send_word(10'h3FF); send_word(10'h123);
    send_word(10'h000); send_word(10'h3FF); send_word(10'h155);
    repeat (3) @(posedge clk);
    chk(got_n == 0, "R1 words outside packets dropped", got_n, 0);
    send_word(10'h000); send_word(10'h3FF); send_word(10'h000);
    run_pkt("R1 resync after broken preamble", mkw(8'h6D), mkw(8'h02), 3, 1'b0);

    summary();
  end
endmodule